// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is the device-side receive path of a small Ethernet-style controller. It walks a ring of receive descriptors in system memory. Each descriptor is four 32-bit words: status, control, buffer address and a second buffer address, which is left unused. When the engine owns the current descriptor, it packs the incoming byte stream into that descriptor's buffer as 32-bit words. At end of frame it writes the status word back with the frame length and with ownership returned to the host. It then pulses `rx_done` and moves on to the next descriptor. A descriptor whose control word has the end-of-ring flag set sends the engine back to `ring_base`.

The host sets descriptors up in memory. It drives `ring_base` and the enable bit, and it pulses `poll` after handing descriptors back to the engine. A host-owned descriptor suspends the engine. While suspended it drops frames until a poll demand arrives. Clearing the enable bit stops the engine only at a frame boundary.

The controller has ten states:
- `ST_STOP`: idle, discards frames.
- `ST_RD_OWN`: reads the status word.
- `ST_CK_OWN`: tests ownership and reads the control word.
- `ST_CK_CTRL`: latches the end-of-ring flag and size, and reads the buffer address.
- `ST_CK_ADDR`: latches the buffer address.
- `ST_IDLE`: waits for a frame.
- `ST_RECV`: stores bytes.
- `ST_WB`: writes the status word back.
- `ST_DONE`: pulses done and advances the pointer.
- `ST_SUSP`: discards frames until a poll.

The transitions are:
- STOP→RD_OWN when enabled and not mid-frame; the pointer is loaded from `ring_base`.
- RD_OWN→STOP when disabled, otherwise RD_OWN→CK_OWN.
- CK_OWN→CK_CTRL when owned, otherwise CK_OWN→SUSP.
- CK_CTRL→CK_ADDR, then CK_ADDR→IDLE.
- IDLE→STOP when disabled, otherwise IDLE→RECV when a byte is offered.
- RECV→WB on the last byte, then WB→DONE, then DONE→RD_OWN.
- SUSP→STOP when disabled, otherwise SUSP→RD_OWN on a poll. Both leave only at a frame boundary.

Top module: `rx_ring_dma`

## Requirements
- R1: After reset `rx_state` is 0, `mem_req` is 0 and `rx_done` is 0.
- R2: Raising `rx_en` loads the descriptor pointer from `ring_base`. The first memory read is the status word at `ring_base`.
- R3: For a descriptor whose status bit 31 is 1, the engine reads the control word at +4 and the buffer address at +8. Frame bytes then go to the buffer as little-endian 32-bit words (byte n lands in word n/4, lane n%4). Unused lanes of the last word are zero.
- R4: After the last byte, the engine writes the status word at descriptor offset 0. Bit 31 is 0, bits 26:16 hold the total byte count of the frame including its 4 CRC bytes, and all other bits are 0.
- R5: `rx_done` is a one-cycle pulse in the cycle after the status write. There is one pulse per stored frame.
- R6: Descriptors are 16 bytes apart. After a descriptor whose control bit 25 is 1, the next descriptor is at `ring_base`.
- R7: The buffer limit is the smaller of control bits 10:0 and `BUF_BYTES` (1536). No buffer word at or past the limit is written, and the length field still counts every byte.
- R8: A descriptor with status bit 31 clear suspends the engine (`rx_state` = 4). A suspended engine issues no memory access, raises no `rx_done` and discards any frame offered.
- R9: A `poll` pulse while suspended re-reads the same descriptor. If it is still host-owned the engine suspends again; if owned, the next frame goes to it.
- R10: Clearing `rx_en` during a frame lets that frame complete with its write-back. `rx_state` then reaches 0, stays 0 while `rx_en` is low, and frames offered meanwhile are discarded.
- R11: `rx_state` encodes 0 stopped, 1 fetching a descriptor, 2 waiting for a frame, 3 receiving, 4 suspended, 5 writing back/done.
- R12: `fr_ready` is 0 while fetching or waiting (codes 1 and 2). The offered byte is then held and not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ring_base | input | AW | Byte address of descriptor 0 |
| rx_en | input | 1 | Receive enable |
| poll | input | 1 | One-cycle poll demand strobe |
| fr_valid | input | 1 | Frame byte valid |
| fr_data | input | 8 | Frame byte |
| fr_last | input | 1 | Marks the last byte of a frame |
| fr_ready | output | 1 | Byte accepted at this edge when high with `fr_valid` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Byte address (word aligned) |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| rx_state | output | 3 | Process state code (R11) |
| rx_done | output | 1 | Frame completed pulse |

## Verification
From the edge after `rx_en` rises, the engine needs five edges to fetch a descriptor and show code 2. The status write falls in the cycle after the last byte is accepted, and `rx_done` follows one cycle later. A host-owned descriptor reaches code 4 three edges after the previous `rx_done`. The bench drives and samples only at falling edges. It checks the done timing by remembering whether the previous cycle carried a status write. It waits for completion with bounded loops and checks suspend and stop states after fixed settling windows longer than those latencies. Memory contents are compared only once `rx_done` has been seen.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    typedef enum logic [3:0] {
        ST_STOP,
        ST_RD_OWN,
        ST_CK_OWN,
        ST_CK_CTRL,
        ST_CK_ADDR,
        ST_IDLE,
        ST_RECV,
        ST_WB,
        ST_DONE,
        ST_SUSP
    } rx_st_e;

    localparam int OWN_BIT      = 31;
    localparam int END_RING_BIT = 25;
    localparam int LEN_LSB      = 16;
    localparam int LEN_W        = 11;
    localparam int DESC_BYTES   = 16;

    // Externally visible process-state code for each controller state
    function automatic logic [2:0] st_code(rx_st_e s);
        logic [2:0] c;
        unique case (s)
            ST_STOP:                          c = 3'd0;
            ST_RD_OWN, ST_CK_OWN,
            ST_CK_CTRL, ST_CK_ADDR:           c = 3'd1;
            ST_IDLE:                          c = 3'd2;
            ST_RECV:                          c = 3'd3;
            ST_SUSP:                          c = 3'd4;
            ST_WB, ST_DONE:                   c = 3'd5;
            default:                          c = 3'd0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr
    import rxr_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          advance,
    input  logic          wrap,
    input  logic [AW-1:0] base,
    output logic [AW-1:0] cur
);

    localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur <= '0;
        end else if (load) begin
            cur <= base;
        end else if (advance) begin
            cur <= wrap ? base : cur + STEP;
        end
    end

endmodule

// File: rtl/rxr_packer.sv
module rxr_packer
    import rxr_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             take,
    input  logic [7:0]       byte_in,
    input  logic             last_in,
    input  logic [AW-1:0]    buf_base,
    input  logic [LEN_W-1:0] buf_limit,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic [31:0]      wr_data,
    output logic [LEN_W-1:0] frame_len
);

    localparam logic [LEN_W-1:0] CNT_MAX = '1;

    logic [LEN_W-1:0] cnt;
    logic [31:0]      acc;
    logic [31:0]      merged;
    logic [1:0]       lane;
    logic             in_buf;
    logic             flush;

    assign lane   = cnt[1:0];
    assign in_buf = cnt < buf_limit;
    assign flush  = (lane == 2'd3) || last_in || (cnt == buf_limit - LEN_W'(1));

    always_comb begin
        merged = acc;
        merged[{lane, 3'b000} +: 8] = byte_in;
    end

    assign wr_en     = take && in_buf && flush;
    assign wr_addr   = buf_base + AW'({cnt[LEN_W-1:2], 2'b00});
    assign wr_data   = merged;
    assign frame_len = cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            acc <= '0;
        end else if (start) begin
            cnt <= '0;
            acc <= '0;
        end else if (take) begin
            cnt <= (cnt == CNT_MAX) ? cnt : cnt + LEN_W'(1);
            acc <= flush ? 32'd0 : merged;
        end
    end

endmodule

// File: rtl/rxr_ctrl.sv
module rxr_ctrl
    import rxr_pkg::*;
#(
    parameter int BUF_BYTES = 1536
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic             poll,
    input  logic             fr_valid,
    input  logic             fr_last,
    input  logic [31:0]      rd_data,
    output rx_st_e           state,
    output logic             fr_ready,
    output logic             take,
    output logic             ld_ptr,
    output logic             adv_ptr,
    output logic             pk_start,
    output logic             desc_wrap,
    output logic [31:0]      buf_addr,
    output logic [LEN_W-1:0] buf_limit,
    output logic             rx_done
);

    localparam logic [LEN_W-1:0] LIM = LEN_W'(BUF_BYTES);

    rx_st_e state_n;
    logic   in_frame;
    logic   poll_pend;

    // State register and per-descriptor context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_STOP;
            in_frame  <= 1'b0;
            poll_pend <= 1'b0;
            desc_wrap <= 1'b0;
            buf_addr  <= '0;
            buf_limit <= '0;
        end else begin
            state     <= state_n;
            poll_pend <= (state == ST_SUSP) && (state_n == ST_SUSP) && (poll_pend || poll);
            if (fr_valid && fr_ready) begin
                in_frame <= !fr_last;
            end
            if (state == ST_CK_CTRL) begin
                desc_wrap <= rd_data[END_RING_BIT];
                buf_limit <= (rd_data[LEN_W-1:0] > LIM) ? LIM : rd_data[LEN_W-1:0];
            end
            if (state == ST_CK_ADDR) begin
                buf_addr <= rd_data;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_STOP:    if (rx_en && !in_frame) state_n = ST_RD_OWN;
            ST_RD_OWN:  state_n = rx_en ? ST_CK_OWN : ST_STOP;
            ST_CK_OWN:  state_n = rd_data[OWN_BIT] ? ST_CK_CTRL : ST_SUSP;
            ST_CK_CTRL: state_n = ST_CK_ADDR;
            ST_CK_ADDR: state_n = ST_IDLE;
            ST_IDLE: begin
                if (!rx_en)        state_n = ST_STOP;
                else if (fr_valid) state_n = ST_RECV;
            end
            ST_RECV:    if (fr_valid && fr_last) state_n = ST_WB;
            ST_WB:      state_n = ST_DONE;
            ST_DONE:    state_n = ST_RD_OWN;
            ST_SUSP: begin
                if (!in_frame) begin
                    if (!rx_en)                 state_n = ST_STOP;
                    else if (poll_pend || poll) state_n = ST_RD_OWN;
                end
            end
            default:    state_n = ST_STOP;
        endcase
    end

    // Outputs
    always_comb begin
        fr_ready = 1'b0;
        unique case (state)
            ST_RECV:          fr_ready = 1'b1;
            ST_STOP, ST_SUSP: fr_ready = (state_n == state);
            default:          fr_ready = 1'b0;
        endcase
        take     = (state == ST_RECV) && fr_valid;
        ld_ptr   = (state == ST_STOP) && (state_n == ST_RD_OWN);
        adv_ptr  = (state == ST_DONE);
        pk_start = (state == ST_IDLE) && (state_n == ST_RECV);
        rx_done  = (state == ST_DONE);
    end

endmodule

// File: rtl/rx_ring_dma.sv
module rx_ring_dma
    import rxr_pkg::*;
#(
    parameter int AW        = 32,
    parameter int BUF_BYTES = 1536
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ring_base,
    input  logic          rx_en,
    input  logic          poll,
    input  logic          fr_valid,
    input  logic [7:0]    fr_data,
    input  logic          fr_last,
    output logic          fr_ready,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic [2:0]    rx_state,
    output logic          rx_done
);

    rx_st_e           st;
    logic             take;
    logic             ld_ptr;
    logic             adv_ptr;
    logic             pk_start;
    logic             desc_wrap;
    logic [31:0]      buf_addr;
    logic [LEN_W-1:0] buf_limit;
    logic [AW-1:0]    cur_addr;
    logic             pk_wr;
    logic [AW-1:0]    pk_addr;
    logic [31:0]      pk_data;
    logic [LEN_W-1:0] pk_len;
    logic [31:0]      status_word;

    rxr_ctrl #(.BUF_BYTES(BUF_BYTES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (rx_en),
        .poll      (poll),
        .fr_valid  (fr_valid),
        .fr_last   (fr_last),
        .rd_data   (mem_rdata),
        .state     (st),
        .fr_ready  (fr_ready),
        .take      (take),
        .ld_ptr    (ld_ptr),
        .adv_ptr   (adv_ptr),
        .pk_start  (pk_start),
        .desc_wrap (desc_wrap),
        .buf_addr  (buf_addr),
        .buf_limit (buf_limit),
        .rx_done   (rx_done)
    );

    rxr_ring_ptr #(.AW(AW)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ld_ptr),
        .advance (adv_ptr),
        .wrap    (desc_wrap),
        .base    (ring_base),
        .cur     (cur_addr)
    );

    rxr_packer #(.AW(AW)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (pk_start),
        .take      (take),
        .byte_in   (fr_data),
        .last_in   (fr_last),
        .buf_base  (AW'(buf_addr)),
        .buf_limit (buf_limit),
        .wr_en     (pk_wr),
        .wr_addr   (pk_addr),
        .wr_data   (pk_data),
        .frame_len (pk_len)
    );

    assign status_word = {1'b0, 4'b0000, pk_len, 16'h0000};
    assign rx_state    = st_code(st);

    // Memory port steering
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_addr;
        mem_wdata = '0;
        unique case (st)
            ST_RD_OWN:  mem_req = 1'b1;
            ST_CK_OWN: begin
                mem_req  = mem_rdata[OWN_BIT];
                mem_addr = cur_addr + AW'(4);
            end
            ST_CK_CTRL: begin
                mem_req  = 1'b1;
                mem_addr = cur_addr + AW'(8);
            end
            ST_RECV: begin
                mem_req   = pk_wr;
                mem_we    = pk_wr;
                mem_addr  = pk_addr;
                mem_wdata = pk_data;
            end
            ST_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = status_word;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rx_ring_dma_chk.sv
module rx_ring_dma_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_en,
    input logic          fr_ready,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          wb_own,
    input logic [2:0]    rx_state,
    input logic          rx_done,
    input logic [AW-1:0] cur_addr,
    input logic [31:0]   buf_addr,
    input logic [10:0]   buf_limit
);

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);

    // R5
    done_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> $past(mem_req && mem_we && (mem_addr == cur_addr) && !wb_own));

    // R4
    wb_clear_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && (mem_addr == cur_addr)) |-> !wb_own);

    // R7
    buf_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && (rx_state == 3'd3)) |->
            ((mem_addr >= AW'(buf_addr)) && ((mem_addr - AW'(buf_addr)) < AW'(buf_limit))));

    // R12
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_state == 3'd1) || (rx_state == 3'd2)) |-> !fr_ready);

    // R10
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_state == 3'd0) && !rx_en) |=> (rx_state == 3'd0));

    // R8
    susp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_state == 3'd4) |-> !mem_req);

endmodule

bind rx_ring_dma rx_ring_dma_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (rx_en),
    .fr_ready  (fr_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .wb_own    (mem_wdata[31]),
    .rx_state  (rx_state),
    .rx_done   (rx_done),
    .cur_addr  (cur_addr),
    .buf_addr  (buf_addr),
    .buf_limit (buf_limit)
);

// File: tb/rx_ring_dma_tb.sv
module rx_ring_dma_tb;

    localparam int          AW     = 32;
    localparam int          MEMW   = 2048;
    localparam logic [31:0] BASE   = 32'h100;
    localparam logic [31:0] SENT   = 32'hDEAD_BEEF;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] ring_base;
    logic        rx_en, poll, fr_valid, fr_last;
    logic [7:0]  fr_data;
    logic        fr_ready, mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [2:0]  rx_state;
    logic        rx_done;

    always #5 clk = ~clk;

    rx_ring_dma #(.AW(AW), .BUF_BYTES(1536)) u_dut (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .rx_en(rx_en), .poll(poll),
        .fr_valid(fr_valid), .fr_data(fr_data), .fr_last(fr_last), .fr_ready(fr_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .rx_state(rx_state), .rx_done(rx_done)
    );

    // Memory model: one-cycle read latency
    logic [31:0] mem [0:MEMW-1];
    always @(posedge clk) begin
        if (mem_req && mem_we)  mem[mem_addr[12:2]] <= mem_wdata;
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[12:2]];
    end

    int n_run = 0, n_fail = 0, m_run = 0, m_fail = 0;
    int wr_cnt = 0, done_cnt = 0;
    logic        prev_stat = 1'b0, got_rd = 1'b0;
    logic [31:0] first_rd = '0;
    logic [7:0]  fb [0:2047];

    // Port monitor, sampled at falling edges
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_done) begin
                m_run++;
                if (!prev_stat) begin
                    m_fail++;
                    $display("FAIL R5 done without status write in prior cycle: actual 0 expected 1");
                end
                done_cnt++;
            end
            prev_stat = mem_req && mem_we && (mem_addr >= BASE) && (mem_addr < BASE + 64) && (mem_addr[3:0] == 4'h0);
            if (mem_req && mem_we) wr_cnt++;
            if (mem_req && !mem_we && !got_rd) begin got_rd = 1'b1; first_rd = mem_addr; end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] bufa(input int i);
        return 32'h400 + 32'(i) * 32'h200;
    endfunction

    task automatic arm(input int i, input int size, input logic [31:0] ba, input bit wrap);
        int d = (BASE >> 2) + i * 4;
        mem[d]     = 32'h8000_0000;
        mem[d + 1] = 32'(size) | (32'(wrap) << 25);
        mem[d + 2] = ba;
        mem[d + 3] = 32'h0;
    endtask

    task automatic fill(input logic [31:0] ba, input int nw);
        for (int w = 0; w < nw; w++) mem[(ba >> 2) + w] = SENT;
    endtask

    task automatic send_frame(input int len);
        bit acc;
        for (int i = 0; i < len; i++) fb[i] = 8'($urandom);
        for (int i = 0; i < len; i++) begin
            fr_valid = 1'b1; fr_data = fb[i]; fr_last = (i == len - 1);
            do begin #1; acc = fr_ready; @(negedge clk); end while (!acc);
        end
        fr_valid = 1'b0; fr_last = 1'b0;
    endtask

    task automatic wait_done(input int dc, input string req);
        int t = 0;
        while (done_cnt == dc && t < 5000) begin @(negedge clk); t++; end
        chk(done_cnt > dc, req, "rx_done seen", 32'(done_cnt - dc), 32'd1);
    endtask

    function automatic logic [7:0] eb(input int b, input int len);
        return (b < len) ? fb[b] : 8'h00;
    endfunction

    task automatic check_frame(input int idx, input int len, input int limit,
                               input logic [31:0] ba, input string req);
        int n = (len < limit) ? len : limit;
        int nw = (n + 3) / 4;
        logic [31:0] e, a;
        bit ok = 1'b1;
        logic [31:0] ba_w, be_w;
        a = mem[(BASE >> 2) + idx * 4];
        chk(a == (32'(len) << 16), "R4", "status word", a, 32'(len) << 16);
        ba_w = '0; be_w = '0;
        for (int w = 0; w < nw; w++) begin
            e = {eb(4*w+3, len), eb(4*w+2, len), eb(4*w+1, len), eb(4*w, len)};
            if (ok && mem[(ba >> 2) + w] != e) begin ok = 1'b0; ba_w = mem[(ba >> 2) + w]; be_w = e; end
        end
        chk(ok, req, "buffer contents", ba_w, be_w);
    endtask

    task automatic run_frame(input int len, input int idx, input int limit,
                             input logic [31:0] ba, input string req);
        int dc = done_cnt;
        send_frame(len);
        wait_done(dc, "R5");
        check_frame(idx, len, limit, ba, req);
    endtask

    task automatic pulse_poll();
        poll = 1'b1; @(negedge clk); poll = 1'b0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run + m_run, n_fail + m_fail);
    endtask

    initial begin
        #1_800_000;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int exp_idx, wc, dc, lens[8];
        void'($urandom(32'd1234));
        rst_n = 1'b0; rx_en = 1'b0; poll = 1'b0; fr_valid = 1'b0; fr_last = 1'b0;
        fr_data = 8'h0; ring_base = BASE;
        for (int i = 0; i < MEMW; i++) mem[i] = SENT;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(rx_state == 3'd0, "R1", "state after reset", 32'(rx_state), 32'd0);
        chk(!mem_req, "R1", "mem_req after reset", 32'(mem_req), 32'd0);
        chk(!rx_done, "R1", "rx_done after reset", 32'(rx_done), 32'd0);

        for (int i = 0; i < 4; i++) arm(i, 512, bufa(i), i == 3);
        got_rd = 1'b0;
        rx_en = 1'b1;
        repeat (6) @(negedge clk);
        // R2 R11 R12: fetched and waiting
        chk(rx_state == 3'd2, "R11", "waiting code", 32'(rx_state), 32'd2);
        chk(first_rd == BASE, "R2", "first read address", first_rd, BASE);

        // R3 R6: random lengths plus short directed frames, ring wraps once
        for (int k = 0; k < 6; k++) lens[k] = 16 + int'($urandom % 480);
        lens[6] = 1; lens[7] = 5;
        exp_idx = 0;
        for (int k = 0; k < 8; k++) begin
            run_frame(lens[k], exp_idx, 512, bufa(exp_idx), (k == 4) ? "R6" : "R3");
            arm(exp_idx, 512, bufa(exp_idx), exp_idx == 3);
            exp_idx = (exp_idx + 1) % 4;
        end

        // R8: next descriptor (1) host-owned
        mem[(BASE >> 2) + 4] = 32'h0;
        run_frame(40, 0, 512, bufa(0), "R3");
        arm(0, 512, bufa(0), 1'b0);
        repeat (8) @(negedge clk);
        chk(rx_state == 3'd4, "R8", "suspended code", 32'(rx_state), 32'd4);
        fill(bufa(1), 16);
        wc = wr_cnt; dc = done_cnt;
        send_frame(30);
        repeat (10) @(negedge clk);
        chk(wr_cnt == wc, "R8", "writes while suspended", 32'(wr_cnt - wc), 32'd0);
        chk(done_cnt == dc, "R8", "done while suspended", 32'(done_cnt - dc), 32'd0);
        chk(mem[bufa(1) >> 2] == SENT, "R8", "buffer untouched", mem[bufa(1) >> 2], SENT);

        // R9: poll with descriptor still host-owned, then owned
        pulse_poll();
        repeat (10) @(negedge clk);
        chk(rx_state == 3'd4, "R9", "re-suspend after poll", 32'(rx_state), 32'd4);
        arm(1, 512, bufa(1), 1'b0);
        pulse_poll();
        repeat (8) @(negedge clk);
        chk(rx_state == 3'd2, "R9", "resume after poll", 32'(rx_state), 32'd2);

        // R7 setup: small size on desc 2, oversize field on desc 3 (ring end)
        arm(2, 8, bufa(2), 1'b0);
        fill(bufa(2), 8);
        arm(3, 2047, 32'h1000, 1'b1);
        fill(32'h1000 + 32'd1528, 4);
        run_frame(64, 1, 512, bufa(1), "R9");
        arm(1, 512, bufa(1), 1'b0);

        run_frame(20, 2, 8, bufa(2), "R7");
        chk(mem[(bufa(2) >> 2) + 2] == SENT, "R7", "word at limit untouched",
            mem[(bufa(2) >> 2) + 2], SENT);
        arm(2, 512, bufa(2), 1'b0);

        run_frame(1600, 3, 1536, 32'h1000, "R7");
        chk(mem[(32'h1000 + 32'd1536) >> 2] == SENT, "R7", "word past cap untouched",
            mem[(32'h1000 + 32'd1536) >> 2], SENT);
        arm(3, 512, bufa(3), 1'b1);

        // R6: wrap after end-of-ring flag
        run_frame(100, 0, 512, bufa(0), "R6");
        arm(0, 512, bufa(0), 1'b0);

        // R10: disable mid-frame, frame still completes
        dc = done_cnt;
        fork
            send_frame(40);
            begin repeat (15) @(negedge clk); rx_en = 1'b0; end
        join
        wait_done(dc, "R10");
        check_frame(1, 40, 512, bufa(1), "R10");
        repeat (10) @(negedge clk);
        chk(rx_state == 3'd0, "R10", "stopped code", 32'(rx_state), 32'd0);
        wc = wr_cnt; dc = done_cnt;
        send_frame(25);
        repeat (5) @(negedge clk);
        chk(wr_cnt == wc, "R10", "writes while stopped", 32'(wr_cnt - wc), 32'd0);
        chk(done_cnt == dc, "R10", "done while stopped", 32'(done_cnt - dc), 32'd0);

        // R2: restart reloads ring base
        got_rd = 1'b0;
        rx_en = 1'b1;
        repeat (6) @(negedge clk);
        chk(first_rd == BASE, "R2", "restart read address", first_rd, BASE);
        chk(rx_state == 3'd2, "R11", "waiting after restart", 32'(rx_state), 32'd2);

        summary();
        $finish;
    end

endmodule